// File: doc/BRIEF.md
# Prioritised Interrupt Source Resolver

The resolver looks at the pending state of a three-level interrupt controller and names the one source that software should service next. Its inputs are a 21-bit summary word and two 32-bit bank words. It produces a flat source number in the range 0 to 71 and a flag that marks the number as valid. Sources 0 to 7 are the summary's own direct sources. Sources 8 to 39 are bank-one bits 0 to 31, and sources 40 to 71 are bank-two bits 0 to 31.

The priority is fixed and is not a plain lowest-bit search. Direct sources win. After them come the shortcut copies of selected bank bits held in the summary word, taken in a listed order. Last come scans of the bank words. These scans run only when the bank's summary flag is set, and they skip every bit that already has a shortcut. A parameter can place a register after the decision, which gives a one-cycle latency.

Top module: `irq_src_resolver`

## Requirements
- R1: When the summary word is all zero, valid is low.
- R2: If any of summary bits 0..7 is set, the result is the number of the lowest one set, from 0 to 7.
- R3: Otherwise, summary bits 10,11,12,13,14 stand for bank-one bits 7,9,10,18,19. They are tested in that order, and the first one set gives 8 plus its bank bit.
- R4: Otherwise, summary bits 15..20 stand for bank-two bits 21,22,23,24,25,30. They are tested in that order, and the first one set gives 40 plus its bank bit.
- R5: Otherwise, if summary bit 8 is set, bank-one bits 7,9,10,18,19 are cleared from the bank-one word. The lowest remaining bit n gives 8+n.
- R6: Otherwise, if summary bit 9 is set, bank-two bits 21..25 and 30 are cleared from the bank-two word. The lowest remaining bit n gives 40+n.
- R7: If a bank flag is set but its cleared bank word is empty, the search moves on. When no stage finds a source, valid is low.
- R8: A bank word has no effect on the result while its summary flag (bit 8 or 9) is clear.
- R9: With REG_OUT=1 the outputs show the decision for the inputs of the previous clock edge. Reset drives valid and index to zero.
- R10: The index reads zero whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sum_pend | input | 21 | Summary pending word |
| bank1_pend | input | 32 | Bank-one pending word |
| bank2_pend | input | 32 | Bank-two pending word |
| src_valid | output | 1 | A source qualified |
| src_idx | output | 7 | Flat number of the chosen source |

## Verification
The assertions assume two things about the inputs. First, the pending words are stable and known at each clock edge. Second, a bank flag set together with an empty bank word is a legal input. The stimulus follows both assumptions. It changes inputs only on the falling edge. It also deliberately sets summary flags whose bank words hold only shortcut positions, or nothing at all. Beyond the directed corner cases, constrained random vectors are drawn with sparse summary words, so that the later stages of the priority chain are reached often.

// File: rtl/irq_resolve_pkg.sv
package irq_resolve_pkg;
    localparam int SUM_W     = 21;
    localparam int BANK_W    = 32;
    localparam int IDX_W     = 7;
    localparam int DIRECT_N  = 8;
    localparam int B1_BASE   = DIRECT_N;
    localparam int B2_BASE   = DIRECT_N + BANK_W;
    localparam int B1_FLAG   = 8;
    localparam int B2_FLAG   = 9;
    localparam int SC1_N     = 5;
    localparam int SC2_N     = 6;
    localparam int SC1_FIRST = 10;
    localparam int SC2_FIRST = SC1_FIRST + SC1_N;
    localparam int POS_W     = $clog2(BANK_W);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [2:0] {
        K_NONE, K_DIRECT, K_SC1, K_SC2, K_SCAN1, K_SCAN2
    } pick_kind_e;

    // bank bit that shortcut k of a bank stands for, in service order
    function automatic int sc_bit(input int bank, input int k);
        int r;
        r = 0;
        if (bank == 1) begin
            case (k)
                0: r = 7;  1: r = 9;  2: r = 10;
                3: r = 18; 4: r = 19; default: r = 0;
            endcase
        end else begin
            case (k)
                0: r = 21; 1: r = 22; 2: r = 23;
                3: r = 24; 4: r = 25; 5: r = 30; default: r = 0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [BANK_W-1:0] sc_mask(input int bank);
        logic [BANK_W-1:0] m;
        int n;
        m = '0;
        n = (bank == 1) ? SC1_N : SC2_N;
        for (int k = 0; k < n; k++) m[sc_bit(bank, k)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lowest_set.sv
module lowest_set #(
    parameter int W     = 32,
    localparam int PW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [PW-1:0] pos
);
    always_comb begin
        found = |vec;
        pos   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/shortcut_pick.sv
module shortcut_pick
    import irq_resolve_pkg::*;
#(
    parameter int BANK = 1,
    parameter int N    = 5,
    parameter int BASE = 8
) (
    input  logic [N-1:0] flags,
    output pick_t        pick
);
    always_comb begin
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (flags[k]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(BASE + sc_bit(BANK, k));
            end
        end
    end
endmodule

// File: rtl/bank_scan.sv
module bank_scan
    import irq_resolve_pkg::*;
#(
    parameter int BANK = 1,
    parameter int BASE = 8
) (
    input  logic              en,
    input  logic [BANK_W-1:0] word,
    output pick_t             pick
);
    localparam logic [BANK_W-1:0] SKIP = sc_mask(BANK);

    logic [BANK_W-1:0] kept;
    logic              hit;
    logic [POS_W-1:0]  pos;

    assign kept = word & ~SKIP;

    lowest_set #(.W(BANK_W)) u_low (.vec(kept), .found(hit), .pos(pos));

    always_comb begin
        pick       = '0;
        pick.valid = en & hit;
        if (pick.valid) pick.idx = IDX_W'(BASE) + IDX_W'(pos);
    end
endmodule

// File: rtl/irq_src_resolver.sv
module irq_src_resolver
    import irq_resolve_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SUM_W-1:0]  sum_pend,
    input  logic [BANK_W-1:0] bank1_pend,
    input  logic [BANK_W-1:0] bank2_pend,
    output logic              src_valid,
    output logic [IDX_W-1:0]  src_idx
);
    localparam int DPW = $clog2(DIRECT_N);

    logic           dir_hit;
    logic [DPW-1:0] dir_pos;
    pick_t          p_sc1, p_sc2, p_scan1, p_scan2;
    pick_t          decided;
    pick_kind_e     kind;

    lowest_set #(.W(DIRECT_N)) u_direct (
        .vec(sum_pend[DIRECT_N-1:0]), .found(dir_hit), .pos(dir_pos));

    shortcut_pick #(.BANK(1), .N(SC1_N), .BASE(B1_BASE)) u_sc1 (
        .flags(sum_pend[SC1_FIRST +: SC1_N]), .pick(p_sc1));

    shortcut_pick #(.BANK(2), .N(SC2_N), .BASE(B2_BASE)) u_sc2 (
        .flags(sum_pend[SC2_FIRST +: SC2_N]), .pick(p_sc2));

    bank_scan #(.BANK(1), .BASE(B1_BASE)) u_scan1 (
        .en(sum_pend[B1_FLAG]), .word(bank1_pend), .pick(p_scan1));

    bank_scan #(.BANK(2), .BASE(B2_BASE)) u_scan2 (
        .en(sum_pend[B2_FLAG]), .word(bank2_pend), .pick(p_scan2));

    always_comb begin
        if (dir_hit)             kind = K_DIRECT;
        else if (p_sc1.valid)    kind = K_SC1;
        else if (p_sc2.valid)    kind = K_SC2;
        else if (p_scan1.valid)  kind = K_SCAN1;
        else if (p_scan2.valid)  kind = K_SCAN2;
        else                     kind = K_NONE;
    end

    always_comb begin
        decided = '0;
        unique case (kind)
            K_DIRECT: begin
                decided.valid = 1'b1;
                decided.idx   = IDX_W'(dir_pos);
            end
            K_SC1:   decided = p_sc1;
            K_SC2:   decided = p_sc2;
            K_SCAN1: decided = p_scan1;
            K_SCAN2: decided = p_scan2;
            default: decided = '0;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            pick_t held;
            always_ff @(posedge clk) begin
                if (rst) held <= '0;
                else     held <= decided;
            end
            assign src_valid = held.valid;
            assign src_idx   = held.idx;

            // R9: output follows the previous cycle's decision
            a_r9_latency: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (src_valid == $past(decided.valid)) && (src_idx == $past(decided.idx)));
        end else begin : g_comb
            assign src_valid = decided.valid;
            assign src_idx   = decided.idx;
        end
    endgenerate

    // R1: empty summary never yields a source
    a_r1_empty: assert property (@(posedge clk) disable iff (rst)
        (sum_pend == '0) |-> !decided.valid);

    // R2: a direct source yields a number below 8
    a_r2_direct: assert property (@(posedge clk) disable iff (rst)
        (|sum_pend[DIRECT_N-1:0]) |-> (decided.valid && decided.idx < IDX_W'(DIRECT_N)));

    // R3: a bank-one shortcut, with no direct source, lands in bank one
    a_r3_sc1_range: assert property (@(posedge clk) disable iff (rst)
        ((sum_pend[DIRECT_N-1:0] == '0) && (|sum_pend[SC1_FIRST +: SC1_N]))
        |-> (decided.idx >= IDX_W'(B1_BASE) && decided.idx < IDX_W'(B2_BASE)));

    // R5: a bank-one scan result never points at a shortcut position
    a_r5_scan_skip: assert property (@(posedge clk) disable iff (rst)
        p_scan1.valid |-> !sc_mask(1)[p_scan1.idx - IDX_W'(B1_BASE)]);

    // R8: bank scans stay silent while their flags are clear
    a_r8_flag_gate: assert property (@(posedge clk) disable iff (rst)
        (!sum_pend[B1_FLAG] && !sum_pend[B2_FLAG]) |-> (!p_scan1.valid && !p_scan2.valid));

    // R10: index is zero when nothing qualifies
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !src_valid |-> (src_idx == '0));
endmodule

// File: tb/sim_irq_src_resolver.sv
`timescale 1ns/1ps
module sim_irq_src_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] sum_pend = '0;
    logic [31:0] bank1_pend = '0;
    logic [31:0] bank2_pend = '0;
    logic        src_valid;
    logic [6:0]  src_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { bit v; int idx; string tag; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    irq_src_resolver u0 (.clk(clk), .rst(rst), .sum_pend(sum_pend),
        .bank1_pend(bank1_pend), .bank2_pend(bank2_pend),
        .src_valid(src_valid), .src_idx(src_idx));

    function automatic exp_t model(input logic [20:0] s, input logic [31:0] b1,
                                   input logic [31:0] b2);
        int l1[5] = '{7, 9, 10, 18, 19};
        int l2[6] = '{21, 22, 23, 24, 25, 30};
        logic [31:0] m1, m2;
        exp_t e;
        e.v = 0; e.idx = 0; e.tag = "";
        for (int i = 0; i < 8; i++) if (s[i]) begin e.v = 1; e.idx = i; return e; end
        for (int k = 0; k < 5; k++) if (s[10+k]) begin e.v = 1; e.idx = 8 + l1[k]; return e; end
        for (int k = 0; k < 6; k++) if (s[15+k]) begin e.v = 1; e.idx = 40 + l2[k]; return e; end
        m1 = b1; m2 = b2;
        foreach (l1[k]) m1[l1[k]] = 1'b0;
        foreach (l2[k]) m2[l2[k]] = 1'b0;
        if (s[8]) for (int n = 0; n < 32; n++) if (m1[n]) begin e.v = 1; e.idx = 8 + n; return e; end
        if (s[9]) for (int n = 0; n < 32; n++) if (m2[n]) begin e.v = 1; e.idx = 40 + n; return e; end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input int av, input int ai,
                         input int ev, input int ei);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
                     tag, av, ai, ev, ei);
        end
    endtask

    task automatic drive(input logic [20:0] s, input logic [31:0] b1,
                         input logic [31:0] b2, input string tag);
        exp_t e;
        @(negedge clk);
        sum_pend = s; bank1_pend = b1; bank2_pend = b2;
        e = model(s, b1, b2);
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: result appears after the edge that follows the drive (R9)
    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(src_valid == e.v && int'(src_idx) == e.idx, e.tag,
                  src_valid, src_idx, e.v, e.idx);
        end
    end

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got valid=x idx=x, expected valid=- idx=-");
        report();
    end

    initial begin
        // R9 reset state with busy inputs
        sum_pend = 21'h1FFFFF; bank1_pend = '1; bank2_pend = '1;
        repeat (3) @(posedge clk);
        #1 check(src_valid == 0 && src_idx == 0, "R9 reset", src_valid, src_idx, 0, 0);
        @(negedge clk); rst = 1'b0;

        drive(21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 empty summary");
        drive(21'h0000A0, 0, 0, "R2 lowest direct 5");
        drive(21'h1FFF80, '1, '1, "R2 direct 7 beats all");
        drive(21'h002800, 0, 0, "R3 shortcut order gives 17");
        drive(21'h004000 | 21'h100000, 0, 0, "R3 bank-one before bank-two");
        drive(21'h120000, 0, 0, "R4 shortcut order gives 63");
        drive(21'h100000, 0, 0, "R4 last shortcut gives 70");
        drive(21'h000100, 32'h0000_1080, 0, "R5 skip bit7 gives 20");
        drive(21'h000100, 32'h0000_0001, 0, "R5 bit0 gives 8");
        drive(21'h000300, 32'h000C_0680, 32'h0000_0008, "R7 empty bank1 moves on, 43");
        drive(21'h000200, 0, 32'h8000_0000, "R6 bit31 gives 71");
        drive(21'h000200, 0, 32'h43E0_0000, "R7 only shortcut bits, none");
        drive(21'h000300, 0, 0, "R7 both flags empty words");
        drive(21'h000000, 32'h1, 32'h1, "R8 words without flags");
        drive(21'h000001, 32'h1, 32'h1, "R8 words ignored 0");
        drive(21'h000200, 32'h1, 32'h0400_0000, "R8 bank1 word ignored, 66");

        for (int i = 0; i < 400; i++) begin
            logic [20:0] s;
            s = 21'($urandom) & 21'($urandom) & 21'($urandom);
            if (i % 3 == 0) s[7:0] = 0;
            if (i % 5 == 0) s[20:10] = 0;
            drive(s, $urandom, $urandom, "R10 random");
        end
        @(negedge clk); sum_pend = 0;
        wait (q.size() == 0);
        @(negedge clk);

        // R9 reset mid-run clears outputs
        sum_pend = 21'h000004;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check(src_valid == 0 && src_idx == 0, "R9 reset mid-run", src_valid, src_idx, 0, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(src_valid == 1 && src_idx == 2, "R9 resume", src_valid, src_idx, 1, 2);
        report();
    end
endmodule